// File: doc/BRIEF.md
# Radio Transmit Frame Assembler

This block turns a payload into a complete transmit frame for a short-range radio and hands it byte by byte to a modulator over a valid/ready stream. A frame starts with a run of preamble bytes and a start-of-frame delimiter. A length byte follows, then the payload, and the frame ends with a 16-bit check value. The check value is accumulated over the payload bytes as they leave the block.

The payload comes from one of two sources, and the source is chosen per frame when `start` is pulsed. In buffered mode the block reads the payload from a local byte RAM. The RAM returns data one cycle after each read. In streaming mode the host hands over multi-byte words one at a time in answer to a request line. If a word is missing when the serializer needs it, the block reports an underrun and abandons the frame. A rejected length, an underrun and a completed frame are each reported by a one-cycle pulse.

Top module: `rf_frame_builder`

## Requirements
- R1: After an accepted `start`, the first four bytes accepted on the output are 0x00.
- R2: The fifth byte is the delimiter 0xA7.
- R3: The sixth byte equals the payload length plus two. It counts the two check bytes, so its largest value is 127.
- R4: With `stream_mode` low at `start`, the payload bytes are those the RAM returns for addresses 0, 1, 2 and so on in order. `buf_data` is taken in the cycle after the `buf_rd` pulse for that address. The RAM is read ahead, so the output is never starved in this mode.
- R5: With `stream_mode` high at `start`, a word moves in on every cycle where `word_req` and `word_valid` are both high. Its bytes are sent least significant first: bits 7:0 go out first. Surplus bytes of the last word are dropped.
- R6: After the payload come two check bytes, low byte first. The check is a CRC-16 over the payload bytes only, with generator 0x1021 in bit-reversed form (0x8408), initial value 0x0000, and each byte processed from bit 0 upward.
- R7: A `start` with a length above 125 produces a one-cycle `len_err` pulse in the next cycle. No frame is emitted and `busy` stays low.
- R8: In streaming mode, if the block is in the payload phase and holds no byte, `underrun` pulses for one cycle and the frame is abandoned: `tx_valid` and `busy` fall.
- R9: `done` is high for exactly one cycle: the cycle after the last check byte is accepted.
- R10: While `tx_valid` is high and `tx_ready` is low, `tx_valid` stays high and `tx_data` does not change.
- R11: A `start` pulse while a frame is in progress is ignored, and the frame in flight completes unchanged.
- R12: A zero-length payload gives a frame whose length byte is 2, followed by the check bytes 0x00 0x00.
- R13: Out of reset and after a frame ends, `tx_valid`, `busy`, `buf_rd` and `word_req` are low until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a frame (single-cycle pulse) |
| stream_mode | input | 1 | Payload source for the frame: 1 = host words, 0 = local RAM |
| pay_len | input | 7 | Payload length in bytes, sampled with `start` |
| len_err | output | 1 | Pulse: requested length refused |
| busy | output | 1 | A frame is in progress |
| done | output | 1 | Pulse: frame finished |
| underrun | output | 1 | Pulse: streaming frame abandoned for lack of data |
| buf_rd | output | 1 | RAM read strobe |
| buf_addr | output | 7 | RAM read address |
| buf_data | input | 8 | RAM read data, valid the cycle after `buf_rd` |
| word_req | output | 1 | Request for the next host word |
| word_valid | input | 1 | Host word present |
| word_data | input | 16 | Host word, byte 0 in bits 7:0 |
| tx_data | output | 8 | Frame byte to the modulator |
| tx_valid | output | 1 | `tx_data` is valid |
| tx_ready | input | 1 | Modulator accepts the byte |

## Verification
The bench builds the block with its defaults: four preamble bytes, a 125-byte payload limit and two-byte host words. Two-byte words mean an odd payload length leaves half a word unused, so the surplus-byte rule can be tested. Running the host at full rate shows that one held word is enough to avoid gaps. The 7-bit length port can carry 126 and 127, so the bench can drive values just above the limit as well as a full 125-byte frame. Backpressure patterns of every other cycle and every third cycle exercise the output hold rule in every frame phase.

// File: rtl/rfb_pkg.sv
package rfb_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_SFD,
    ST_LEN,
    ST_PAY,
    ST_CHK_LO,
    ST_CHK_HI
  } rfb_state_e;

  // Bit-serial reflected CRC-16 update, bit 0 of the byte first.
  function automatic logic [15:0] rfb_crc_byte(input logic [15:0] crc_in,
                                               input logic [7:0]  data);
    logic [15:0] c;
    c = crc_in;
    for (int i = 0; i < 8; i++) begin
      if (c[0] ^ data[i]) c = (c >> 1) ^ 16'h8408;
      else                c = c >> 1;
    end
    return c;
  endfunction

  // The length byte also counts the two trailing check bytes.
  function automatic logic [7:0] rfb_len_field(input logic [7:0] pay_bytes);
    return pay_bytes + 8'd2;
  endfunction

endpackage

// File: rtl/rfb_crc16.sv
module rfb_crc16
  import rfb_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clear,
  input  logic        en,
  input  logic [7:0]  din,
  output logic [15:0] crc
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     crc <= '0;
    else if (clear) crc <= '0;
    else if (en)    crc <= rfb_crc_byte(crc, din);
  end

  AST_CRC_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> crc == 16'h0000); // R6
  AST_CRC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !en) |=> $stable(crc)); // R6

endmodule

// File: rtl/rfb_seq.sv
module rfb_seq
  import rfb_pkg::*;
#(
  parameter int PRE_LEN = 4,
  parameter int MAX_PAY = 125,
  parameter int LEN_W   = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             stream_in,
  input  logic [LEN_W-1:0] req_len,
  input  logic             tx_ready,
  input  logic             src_avail,
  output rfb_state_e       st,
  output logic [LEN_W-1:0] len_q,
  output logic             stream_q,
  output logic             launch,
  output logic             tx_valid,
  output logic             pay_take,
  output logic             busy,
  output logic             len_err,
  output logic             done,
  output logic             underrun
);

  localparam int PC_W = (PRE_LEN > 1) ? $clog2(PRE_LEN) : 1;

  logic [PC_W-1:0]  pre_cnt;
  logic [LEN_W-1:0] pay_cnt;
  logic             len_ok;
  logic             hs;
  logic             starve;

  assign len_ok   = int'(req_len) <= MAX_PAY;
  assign launch   = (st == ST_IDLE) && start && len_ok;
  assign tx_valid = (st != ST_IDLE) && ((st != ST_PAY) || src_avail);
  assign hs       = tx_valid && tx_ready;
  assign pay_take = (st == ST_PAY) && hs;
  assign starve   = (st == ST_PAY) && stream_q && !src_avail;
  assign busy     = (st != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      pre_cnt  <= '0;
      pay_cnt  <= '0;
      len_q    <= '0;
      stream_q <= 1'b0;
      len_err  <= 1'b0;
      done     <= 1'b0;
      underrun <= 1'b0;
    end else begin
      len_err  <= 1'b0;
      done     <= 1'b0;
      underrun <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (start) begin
            if (len_ok) begin
              st       <= ST_PRE;
              len_q    <= req_len;
              stream_q <= stream_in;
              pre_cnt  <= '0;
            end else begin
              len_err <= 1'b1;
            end
          end
        end
        ST_PRE: begin
          if (hs) begin
            if (pre_cnt == PC_W'(PRE_LEN - 1)) st <= ST_SFD;
            else pre_cnt <= pre_cnt + 1'b1;
          end
        end
        ST_SFD: if (hs) st <= ST_LEN;
        ST_LEN: begin
          if (hs) begin
            pay_cnt <= '0;
            st      <= (len_q == '0) ? ST_CHK_LO : ST_PAY;
          end
        end
        ST_PAY: begin
          if (starve) begin
            underrun <= 1'b1;
            st       <= ST_IDLE;
          end else if (hs) begin
            pay_cnt <= pay_cnt + 1'b1;
            if (pay_cnt == len_q - 1'b1) st <= ST_CHK_LO;
          end
        end
        ST_CHK_LO: if (hs) st <= ST_CHK_HI;
        ST_CHK_HI: begin
          if (hs) begin
            st   <= ST_IDLE;
            done <= 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  AST_LEN_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && start && int'(req_len) > MAX_PAY) |=> (len_err && st == ST_IDLE)); // R7
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_CHK_HI && tx_ready) |=> done); // R9
  AST_VALID_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> tx_valid); // R10
  AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(len_q)); // R11
  AST_UNDERRUN_STREAM_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |-> (stream_q && st == ST_IDLE)); // R8

endmodule

// File: rtl/rfb_src.sv
module rfb_src #(
  parameter int LEN_W      = 7,
  parameter int WORD_BYTES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    launch,
  input  logic                    stream_in,
  input  logic [LEN_W-1:0]        launch_len,
  input  logic                    active,
  input  logic                    take,
  output logic                    buf_rd,
  output logic [LEN_W-1:0]        buf_addr,
  input  logic [7:0]              buf_data,
  output logic                    word_req,
  input  logic                    word_valid,
  input  logic [WORD_BYTES*8-1:0] word_data,
  output logic [7:0]              src_byte,
  output logic                    src_avail
);

  localparam int WW   = WORD_BYTES * 8;
  localparam int WSH  = $clog2(WORD_BYTES);
  localparam int SC_W = $clog2(WORD_BYTES + 1);

  logic             mode_s;
  logic             take_b;
  logic             take_s;

  // RAM-fed path: one read in flight or one byte held, with bypass.
  logic [LEN_W-1:0] fetch_left;
  logic [LEN_W-1:0] addr_q;
  logic             rd_pend;
  logic             pb_v;
  logic [7:0]       pb;

  // Host-fed path: one waiting word plus a shifting word.
  logic [WW-1:0]    ws;
  logic             ws_v;
  logic [WW-1:0]    sh;
  logic [WW-1:0]    sh_next;
  logic [SC_W-1:0]  sh_cnt;
  logic [LEN_W-1:0] wreq_left;
  logic [LEN_W:0]   wround;
  logic [LEN_W-1:0] words;
  logic             w_acc;
  logic             w_load;

  assign take_b = take && !mode_s;
  assign take_s = take && mode_s;

  assign wround = {1'b0, launch_len} + (LEN_W + 1)'(WORD_BYTES - 1);
  assign words  = LEN_W'(wround >> WSH);

  assign buf_rd   = active && !mode_s && (fetch_left != '0) &&
                    ((!pb_v && !rd_pend) || take_b);
  assign buf_addr = addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_s     <= 1'b0;
      fetch_left <= '0;
      addr_q     <= '0;
      rd_pend    <= 1'b0;
      pb_v       <= 1'b0;
      pb         <= '0;
    end else if (launch) begin
      mode_s     <= stream_in;
      fetch_left <= launch_len;
      addr_q     <= '0;
      rd_pend    <= 1'b0;
      pb_v       <= 1'b0;
    end else begin
      rd_pend <= buf_rd;
      if (buf_rd) begin
        addr_q     <= addr_q + 1'b1;
        fetch_left <= fetch_left - 1'b1;
      end
      if (rd_pend && !take_b) begin
        pb   <= buf_data;
        pb_v <= 1'b1;
      end else if (pb_v && take_b) begin
        pb_v <= 1'b0;
      end
    end
  end

  generate
    if (WORD_BYTES == 1) begin : g_byte_word
      assign sh_next = '0;
    end else begin : g_wide_word
      assign sh_next = {8'h00, sh[WW-1:8]};
    end
  endgenerate

  assign word_req = active && mode_s && !ws_v && (wreq_left != '0);
  assign w_acc    = word_req && word_valid;
  assign w_load   = ws_v && ((sh_cnt == '0) || ((sh_cnt == SC_W'(1)) && take_s));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ws        <= '0;
      ws_v      <= 1'b0;
      sh        <= '0;
      sh_cnt    <= '0;
      wreq_left <= '0;
    end else if (launch) begin
      ws_v      <= 1'b0;
      sh_cnt    <= '0;
      wreq_left <= words;
    end else begin
      if (w_acc) begin
        ws        <= word_data;
        ws_v      <= 1'b1;
        wreq_left <= wreq_left - 1'b1;
      end else if (w_load) begin
        ws_v <= 1'b0;
      end
      if (w_load) begin
        sh     <= ws;
        sh_cnt <= SC_W'(WORD_BYTES);
      end else if (take_s) begin
        sh     <= sh_next;
        sh_cnt <= sh_cnt - 1'b1;
      end
    end
  end

  assign src_byte  = mode_s ? sh[7:0] : (pb_v ? pb : buf_data);
  assign src_avail = mode_s ? (sh_cnt != '0) : (pb_v || rd_pend);

  AST_ONE_BYTE_STAGED: assert property (@(posedge clk) disable iff (!rst_n)
    !(pb_v && rd_pend)); // R4
  AST_RD_IN_BUF_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    buf_rd |-> (!mode_s && active)); // R4
  AST_REQ_IN_STREAM_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    word_req |-> (mode_s && active)); // R5
  AST_TAKE_HAS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> src_avail); // R5

endmodule

// File: rtl/rf_frame_builder.sv
module rf_frame_builder
  import rfb_pkg::*;
#(
  parameter int         PRE_LEN    = 4,
  parameter logic [7:0] PRE_BYTE   = 8'h00,
  parameter logic [7:0] SFD_BYTE   = 8'hA7,
  parameter int         MAX_PAY    = 125,
  parameter int         WORD_BYTES = 2,
  parameter int         LEN_W      = $clog2(MAX_PAY + 3)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic                    stream_mode,
  input  logic [LEN_W-1:0]        pay_len,
  output logic                    len_err,
  output logic                    busy,
  output logic                    done,
  output logic                    underrun,
  output logic                    buf_rd,
  output logic [LEN_W-1:0]        buf_addr,
  input  logic [7:0]              buf_data,
  output logic                    word_req,
  input  logic                    word_valid,
  input  logic [WORD_BYTES*8-1:0] word_data,
  output logic [7:0]              tx_data,
  output logic                    tx_valid,
  input  logic                    tx_ready
);

  rfb_state_e       st;
  logic [LEN_W-1:0] len_q;
  logic             stream_q;
  logic             launch;
  logic             pay_take;
  logic [7:0]       src_byte;
  logic             src_avail;
  logic [15:0]      crc;

  rfb_seq #(
    .PRE_LEN (PRE_LEN),
    .MAX_PAY (MAX_PAY),
    .LEN_W   (LEN_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .stream_in (stream_mode),
    .req_len   (pay_len),
    .tx_ready  (tx_ready),
    .src_avail (src_avail),
    .st        (st),
    .len_q     (len_q),
    .stream_q  (stream_q),
    .launch    (launch),
    .tx_valid  (tx_valid),
    .pay_take  (pay_take),
    .busy      (busy),
    .len_err   (len_err),
    .done      (done),
    .underrun  (underrun)
  );

  rfb_src #(
    .LEN_W      (LEN_W),
    .WORD_BYTES (WORD_BYTES)
  ) u_src (
    .clk        (clk),
    .rst_n      (rst_n),
    .launch     (launch),
    .stream_in  (stream_mode),
    .launch_len (pay_len),
    .active     (busy),
    .take       (pay_take),
    .buf_rd     (buf_rd),
    .buf_addr   (buf_addr),
    .buf_data   (buf_data),
    .word_req   (word_req),
    .word_valid (word_valid),
    .word_data  (word_data),
    .src_byte   (src_byte),
    .src_avail  (src_avail)
  );

  rfb_crc16 u_crc (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (launch),
    .en    (pay_take),
    .din   (src_byte),
    .crc   (crc)
  );

  always_comb begin
    unique case (st)
      ST_PRE:    tx_data = PRE_BYTE;
      ST_SFD:    tx_data = SFD_BYTE;
      ST_LEN:    tx_data = rfb_len_field(8'(len_q));
      ST_PAY:    tx_data = src_byte;
      ST_CHK_LO: tx_data = crc[7:0];
      ST_CHK_HI: tx_data = crc[15:8];
      default:   tx_data = 8'h00;
    endcase
  end

  AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> $stable(tx_data)); // R10
  AST_BUF_NEVER_STARVES: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_PAY && !stream_q) |-> src_avail); // R4
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!buf_rd && !word_req && !tx_valid)); // R13
  AST_FRAME_OPENS_WITH_PREAMBLE: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> (tx_valid && tx_data == PRE_BYTE)); // R1

endmodule

// File: tb/rf_frame_builder_test.sv
module rf_frame_builder_test;

  localparam int CLK_PERIOD = 10;
  localparam int WB         = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        stream_mode = 1'b0;
  logic [6:0]  pay_len = '0;
  logic        len_err, busy, done, underrun, buf_rd, word_req, tx_valid;
  logic [6:0]  buf_addr;
  logic [7:0]  buf_data = '0;
  logic        word_valid = 1'b0;
  logic [15:0] word_data = '0;
  logic [7:0]  tx_data;
  logic        tx_ready = 1'b1;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int ready_pat = 0;
  logic [7:0] mem [0:255];
  logic [7:0] cap [0:255];
  int cap_n = 0;
  int last_hs = -10;
  int done_cnt = 0;
  int done_bad = 0;
  int uflow_cnt = 0;
  int hold_bad = 0;
  int widx = 0;
  int stall_lim = 1000;

  // Stimulus table: mode[17], length[16:10], seed[9:2], ready pattern[1:0]
  localparam logic [17:0] VEC [0:5] = '{
    {1'b0, 7'd5,  8'h11, 2'd0},
    {1'b0, 7'd17, 8'hC3, 2'd1},
    {1'b1, 7'd8,  8'h20, 2'd0},
    {1'b1, 7'd9,  8'h7E, 2'd2},
    {1'b0, 7'd1,  8'hF0, 2'd2},
    {1'b1, 7'd3,  8'h05, 2'd1}
  };

  rf_frame_builder uut (
    .clk(clk), .rst_n(rst_n), .start(start), .stream_mode(stream_mode),
    .pay_len(pay_len), .len_err(len_err), .busy(busy), .done(done),
    .underrun(underrun), .buf_rd(buf_rd), .buf_addr(buf_addr),
    .buf_data(buf_data), .word_req(word_req), .word_valid(word_valid),
    .word_data(word_data), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  // Byte-wise CRC update, table-free nibble form.
  function automatic logic [15:0] model_crc(input logic [15:0] c, input logic [7:0] b);
    logic [7:0] x;
    x = c[7:0] ^ b;
    x = x ^ (x << 4);
    return {8'h00, c[15:8]} ^ {x, 8'h00} ^ {5'b0, x, 3'b0} ^ {12'h000, x[7:4]};
  endfunction

  function automatic logic [15:0] mkword(input int k);
    return {mem[(2 * k + 1) & 255], mem[(2 * k) & 255]};
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Cycle counter and backpressure pattern
  initial forever begin
    @(posedge clk);
    cyc++;
    #1;
    case (ready_pat)
      0:       tx_ready = 1'b1;
      1:       tx_ready = cyc[0];
      default: tx_ready = (cyc % 3) != 0;
    endcase
  end

  // RAM with one cycle of read latency
  initial forever begin
    logic rd;
    logic [6:0] a;
    @(negedge clk);
    rd = buf_rd;
    a = buf_addr;
    @(posedge clk);
    #1;
    if (rd) buf_data = mem[a];
  end

  // Host word supplier
  initial forever begin
    logic acc;
    @(negedge clk);
    acc = word_req && word_valid;
    @(posedge clk);
    #1;
    if (acc) begin
      widx++;
      word_data = mkword(widx);
      word_valid = (widx < stall_lim);
    end
  end

  // Output monitor
  initial begin
    logic pv, pr;
    logic [7:0] pd;
    pv = 1'b0; pr = 1'b0; pd = '0;
    forever begin
      @(negedge clk);
      if (pv && !pr && (!tx_valid || tx_data != pd)) hold_bad++;
      pv = tx_valid; pr = tx_ready; pd = tx_data;
      if (tx_valid && tx_ready) begin
        cap[cap_n & 255] = tx_data;
        cap_n++;
        last_hs = cyc;
      end
      if (done) begin
        done_cnt++;
        if (cyc != last_hs + 1) done_bad++;
      end
      if (underrun) uflow_cnt++;
    end
  end

  task automatic run_frame(input bit smode, input int n, input logic [7:0] seed,
                           input int rpat, input int stall_words, input bit poke);
    logic [7:0] exp_b [0:255];
    logic [15:0] c;
    int exp_n;
    int t;
    bit abort;
    string tag;
    abort = (stall_words * WB) < n;
    for (int i = 0; i < 256; i++) mem[i] = seed + 8'(i * 29);
    for (int i = 0; i < 4; i++) exp_b[i] = 8'h00;
    exp_b[4] = 8'hA7;
    exp_b[5] = 8'(n + 2);
    c = 16'h0000;
    for (int i = 0; i < n; i++) begin
      exp_b[6 + i] = mem[i];
      c = model_crc(c, mem[i]);
    end
    exp_b[6 + n] = c[7:0];
    exp_b[7 + n] = c[15:8];
    exp_n = abort ? 6 + stall_words * WB : n + 8;
    cap_n = 0; done_cnt = 0; done_bad = 0; uflow_cnt = 0; hold_bad = 0;
    widx = 0; stall_lim = stall_words;
    word_data = mkword(0);
    word_valid = (stall_words > 0);
    ready_pat = rpat;
    @(posedge clk); #1;
    start = 1'b1; pay_len = 7'(n); stream_mode = smode;
    @(posedge clk); #1;
    start = 1'b0;
    if (poke) begin
      repeat (5) @(posedge clk);
      #1; start = 1'b1; pay_len = 7'd3; stream_mode = ~smode;
      @(posedge clk); #1; start = 1'b0;
    end
    t = 0;
    while (done_cnt == 0 && uflow_cnt == 0 && t < 3000) begin
      @(negedge clk);
      t++;
    end
    repeat (2) @(negedge clk);
    if (abort) begin
      chk(uflow_cnt == 1, "R8 underrun pulse count", uflow_cnt, 1);
      chk(!busy && !tx_valid, "R8 frame abandoned", int'(busy) + int'(tx_valid), 0);
      chk(done_cnt == 0, "R8 no done after abort", done_cnt, 0);
    end else begin
      chk(done_cnt == 1, "R9 done high exactly one cycle", done_cnt, 1);
      chk(done_bad == 0, "R9 done one cycle after last byte", done_bad, 0);
      chk(uflow_cnt == 0, "R8 no underrun when fed", uflow_cnt, 0);
    end
    chk(hold_bad == 0, "R10 output held under backpressure", hold_bad, 0);
    chk(cap_n == exp_n, poke ? "R11 frame length with start while busy" : "frame length",
        cap_n, exp_n);
    for (int i = 0; i < exp_n && i < cap_n; i++) begin
      if (n == 0)          tag = "R12 empty-payload frame byte";
      else if (i < 4)      tag = "R1 preamble byte";
      else if (i == 4)     tag = "R2 delimiter byte";
      else if (i == 5)     tag = "R3 length byte";
      else if (i < 6 + n)  tag = smode ? "R5 streamed payload byte" : "R4 buffered payload byte";
      else                 tag = "R6 check byte";
      chk(cap[i] == exp_b[i], tag, int'(cap[i]), int'(exp_b[i]));
    end
    @(negedge clk);
    chk(!tx_valid && !busy && !buf_rd && !word_req, "R13 quiet after frame",
        int'(tx_valid) + int'(busy) + int'(buf_rd) + int'(word_req), 0);
    word_valid = 1'b0;
  endtask

  task automatic try_reject(input int n);
    int seen;
    @(posedge clk); #1;
    start = 1'b1; pay_len = 7'(n); stream_mode = 1'b0;
    @(posedge clk); #1;
    start = 1'b0;
    @(negedge clk);
    chk(len_err == 1'b1, "R7 len_err after oversize start", int'(len_err), 1);
    seen = 0;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      if (tx_valid || busy || buf_rd || len_err) seen++;
    end
    chk(seen == 0, "R7 no frame for oversize length", seen, 0);
  endtask

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!tx_valid && !busy && !done && !buf_rd && !word_req, "R13 quiet in reset",
        int'(tx_valid) + int'(busy) + int'(done) + int'(buf_rd) + int'(word_req), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!tx_valid && !busy && !len_err && !underrun, "R13 quiet after reset",
        int'(tx_valid) + int'(busy) + int'(len_err) + int'(underrun), 0);

    for (int v = 0; v < 6; v++)
      run_frame(VEC[v][17], int'(VEC[v][16:10]), VEC[v][9:2], int'(VEC[v][1:0]), 1000, 1'b0);

    run_frame(1'b0, 125, 8'h5A, 0, 1000, 1'b0);   // R4 longest payload
    run_frame(1'b0, 0, 8'h01, 1, 1000, 1'b0);     // R12 buffered, empty
    run_frame(1'b1, 0, 8'h02, 0, 1000, 1'b0);     // R12 streamed, empty
    run_frame(1'b1, 11, 8'h33, 0, 1000, 1'b1);    // R11 start while busy
    run_frame(1'b1, 12, 8'h44, 0, 2, 1'b0);       // R8 host stops after two words
    try_reject(126);                               // R7
    try_reject(127);                               // R7
    run_frame(1'b1, 7, 8'h9C, 2, 1000, 1'b0);     // recovery after abort

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule